// File: doc/BRIEF.md
# Prefetching Stream Input Unit

This block is the read half of a descriptor-driven DMA engine that feeds a streaming datapath. An external address generator presents one 16-bit element address per handshake. The unit gathers those addresses into 32-bit bus line reads and sends them out well before the datapath asks for the data. Each request it has sent is remembered in an address queue. When a line comes back it is parked in a one-line buffer. An alignment stage then picks the wanted halfwords out of that line and appends them, in the order the addresses arrived, to a stream buffer. The datapath drains the stream buffer through a valid/ready port.

Requests are formed by a three-state machine:
- EMPTY: no element is pending. The next offered address is accepted, which moves the machine to OPEN.
- OPEN: one element is pending. If the address offered in this cycle lies in the same line, it is accepted and merged (OPEN to SEND, merged). Otherwise nothing is accepted (OPEN to SEND, closed).
- SEND: the line request is presented on the bus. The machine returns to EMPTY once the request is taken.

A request is only presented when two conditions hold. First, the stream buffer must have room for every element already promised plus the elements of this request. Second, the address queue must have a free slot. Because of this, a returning line can always be taken without back-pressure on the bus.

Top module: `stream_prefetch_in`

## Requirements
- R1: While reset is asserted and directly after its release, `rq_valid` and `el_valid` are 0 and `ea_ready` is 1.
- R2: Element addresses are byte addresses. The line address sent on `rq_addr` is the element address with bits [1:0] forced to 0. Bit 0 of an element address is ignored.
- R3: An address accepted in EMPTY and the address accepted directly after it in OPEN are merged into one request only when both share address bits [ADDR_W-1:2]. If the next address lies in another line, or if no address is offered in the OPEN cycle, a single-element request is sent.
- R4: The number of elements requested but not yet delivered at `el_*` never exceeds SBUF_DEPTH. The number of requests taken but not yet answered never exceeds AQ_DEPTH.
- R5: Responses arrive in request order, one per `rs_valid` pulse. The element for address A is `rs_data[31:16]` when A[1] is 1 and `rs_data[15:0]` when A[1] is 0.
- R6: Elements leave on `el_data` in exactly the order their addresses were accepted. This includes a merged pair whose second address is the lower half, and a merged pair that repeats the same address.
- R7: `el_valid` is 0 whenever no extracted element is waiting. While `el_valid` is 1 and `el_ready` is 0, `el_valid` and `el_data` hold.
- R8: While `rq_valid` is 1 and `rq_ready` is 0, `rq_valid` and `rq_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_valid | input | 1 | Element address offered |
| ea_ready | output | 1 | Element address accepted this cycle |
| ea_addr | input | ADDR_W | Element byte address |
| rq_valid | output | 1 | Line read request presented |
| rq_ready | input | 1 | Bus takes the request |
| rq_addr | output | ADDR_W | Line-aligned request address |
| rs_valid | input | 1 | Read data returned (in request order) |
| rs_data | input | 32 | Returned bus line |
| el_valid | output | 1 | Stream element available |
| el_ready | input | 1 | Datapath takes the element |
| el_data | output | 16 | Stream element |

## Verification
The hardest situation to reach is the one where both prefetch limits bind together. This needs a full address queue, a stream buffer already promised to the limit, and a request waiting in SEND with the bus stalled. It only appears when bus latency is long, the consumer stalls, and mostly unmerged requests pile up.

The stimulus reaches it in two ways. One case holds `el_ready` low for many cycles on a long ascending stream. Another case mixes strides that break merging with a twelve-cycle response latency and pseudo-random `rq_ready` and `el_ready`. A behavioural model checks both limits on every clock, along with request addresses and element order.

// File: rtl/sipf_pkg.sv
package sipf_pkg;
    localparam int LINE_W  = 32;
    localparam int ELEM_W  = 16;
    localparam int PER_LINE = LINE_W / ELEM_W;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_OPEN  = 2'd1,
        ST_SEND  = 2'd2
    } mrg_state_t;

    // Extraction tag stored per outstanding line request
    typedef struct packed {
        logic two;   // two elements taken from this line
        logic sel0;  // half of first element
        logic sel1;  // half of second element
    } line_tag_t;
endpackage

// File: rtl/sipf_merge_fsm.sv
module sipf_merge_fsm
    import sipf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SBUF_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ea_valid,
    input  logic [ADDR_W-1:0] ea_addr,
    output logic              ea_ready,
    output logic              rq_valid,
    input  logic              rq_ready,
    output logic [ADDR_W-1:0] rq_addr,
    input  logic              aq_full,
    output logic              issue,
    output line_tag_t         issue_tag,
    input  logic              el_pop
);
    localparam int CRW = $clog2(SBUF_DEPTH + 1) + 1;

    mrg_state_t        state_q, state_d;
    logic [ADDR_W-3:0] pend_line_q;
    logic              pend_two_q, pend_sel0_q, pend_sel1_q;
    logic [CRW-1:0]    resv_q;
    logic [CRW-1:0]    pend_cnt;
    logic              same_line, credit_ok;

    assign same_line = (ea_addr[ADDR_W-1:2] == pend_line_q);
    assign pend_cnt  = pend_two_q ? CRW'(2) : CRW'(1);
    assign credit_ok = (resv_q + pend_cnt) <= CRW'(SBUF_DEPTH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (ea_valid) state_d = ST_OPEN;
            ST_OPEN:  state_d = ST_SEND;   // merged or closed
            ST_SEND:  if (issue) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        ea_ready = 1'b0;
        rq_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: ea_ready = 1'b1;
            ST_OPEN:  ea_ready = same_line;
            ST_SEND:  rq_valid = credit_ok && !aq_full;
            default:  ;
        endcase
    end

    assign issue     = rq_valid && rq_ready;
    assign rq_addr   = {pend_line_q, 2'b00};
    assign issue_tag = '{two: pend_two_q, sel0: pend_sel0_q, sel1: pend_sel1_q};

    // pending request contents
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_line_q <= '0;
            pend_two_q  <= 1'b0;
            pend_sel0_q <= 1'b0;
            pend_sel1_q <= 1'b0;
        end else if (state_q == ST_EMPTY && ea_valid) begin
            pend_line_q <= ea_addr[ADDR_W-1:2];
            pend_sel0_q <= ea_addr[1];
            pend_two_q  <= 1'b0;
        end else if (state_q == ST_OPEN && ea_valid && same_line) begin
            pend_sel1_q <= ea_addr[1];
            pend_two_q  <= 1'b1;
        end
    end

    // elements promised to the stream buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resv_q <= '0;
        else        resv_q <= resv_q + (issue ? pend_cnt : CRW'(0)) - (el_pop ? CRW'(1) : CRW'(0));
    end

    // R8
    rq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid && !rq_ready |=> rq_valid && $stable(rq_addr));

    // R4
    credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resv_q <= CRW'(SBUF_DEPTH));
endmodule

// File: rtl/sipf_addr_q.sv
module sipf_addr_q
    import sipf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  line_tag_t push_tag,
    output logic      full,
    input  logic      pop,
    output line_tag_t head_tag,
    output logic      empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    line_tag_t   slot_q [DEPTH];
    logic        vld_q  [DEPTH];
    logic [PW-1:0] wp_q, rp_q;

    assign full     = vld_q[wp_q];
    assign empty    = !vld_q[rp_q];
    assign head_tag = slot_q[rp_q];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           vld_q[i] <= 1'b0;
            else if (push && wp_q == PW'(i))      vld_q[i] <= 1'b1;
            else if (pop  && rp_q == PW'(i))      vld_q[i] <= 1'b0;
        end
        always_ff @(posedge clk) begin
            if (push && wp_q == PW'(i)) slot_q[i] <= push_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q <= '0;
            rp_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + PW'(1);
            if (pop)  rp_q <= rp_q + PW'(1);
        end
    end

    // R5
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R4
    push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
endmodule

// File: rtl/sipf_align.sv
module sipf_align
    import sipf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rs_valid,
    input  logic [LINE_W-1:0] rs_data,
    input  line_tag_t         rs_tag,
    output logic [1:0]        wr_n,
    output logic [ELEM_W-1:0] wr_d0,
    output logic [ELEM_W-1:0] wr_d1
);
    logic              lb_valid_q;
    logic [LINE_W-1:0] lb_data_q;
    line_tag_t         lb_tag_q;

    // one-line buffer, drained every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lb_valid_q <= 1'b0;
        else        lb_valid_q <= rs_valid;
    end

    always_ff @(posedge clk) begin
        if (rs_valid) begin
            lb_data_q <= rs_data;
            lb_tag_q  <= rs_tag;
        end
    end

    function automatic logic [ELEM_W-1:0] pick(logic [LINE_W-1:0] line, logic sel);
        return line[sel*ELEM_W +: ELEM_W];
    endfunction

    always_comb begin
        wr_n  = 2'd0;
        if (lb_valid_q) wr_n = lb_tag_q.two ? 2'd2 : 2'd1;
        wr_d0 = pick(lb_data_q, lb_tag_q.sel0);
        wr_d1 = pick(lb_data_q, lb_tag_q.sel1);
    end
endmodule

// File: rtl/sipf_stream_buf.sv
module sipf_stream_buf
    import sipf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        wr_n,
    input  logic [ELEM_W-1:0] wr_d0,
    input  logic [ELEM_W-1:0] wr_d1,
    input  logic              rd_en,
    output logic [ELEM_W-1:0] rd_data,
    output logic              not_empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [ELEM_W-1:0] mem_q [DEPTH];
    logic [PW-1:0]     wp_q, rp_q;
    logic [CW-1:0]     cnt_q;

    assign not_empty = (cnt_q != '0);
    assign rd_data   = mem_q[rp_q];

    always_ff @(posedge clk) begin
        if (wr_n != 2'd0) mem_q[wp_q]          <= wr_d0;
        if (wr_n == 2'd2) mem_q[wp_q + PW'(1)] <= wr_d1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_q + PW'(wr_n);
            if (rd_en) rp_q <= rp_q + PW'(1);
            cnt_q <= cnt_q + CW'(wr_n) - (rd_en ? CW'(1) : CW'(0));
        end
    end

    // R4
    sbuf_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) + int'(wr_n)) <= DEPTH);

    // R7
    sbuf_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> cnt_q != '0);
endmodule

// File: rtl/stream_prefetch_in.sv
module stream_prefetch_in
    import sipf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SBUF_DEPTH = 8,
    parameter int AQ_DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ea_valid,
    output logic              ea_ready,
    input  logic [ADDR_W-1:0] ea_addr,
    output logic              rq_valid,
    input  logic              rq_ready,
    output logic [ADDR_W-1:0] rq_addr,
    input  logic              rs_valid,
    input  logic [LINE_W-1:0] rs_data,
    output logic              el_valid,
    input  logic              el_ready,
    output logic [ELEM_W-1:0] el_data
);
    logic              issue, aq_full, aq_empty, el_pop;
    line_tag_t         issue_tag, head_tag;
    logic [1:0]        wr_n;
    logic [ELEM_W-1:0] wr_d0, wr_d1;

    assign el_pop = el_valid && el_ready;

    sipf_merge_fsm #(.ADDR_W(ADDR_W), .SBUF_DEPTH(SBUF_DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_ready(ea_ready),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
        .aq_full(aq_full), .issue(issue), .issue_tag(issue_tag),
        .el_pop(el_pop)
    );

    sipf_addr_q #(.DEPTH(AQ_DEPTH)) u_aq (
        .clk(clk), .rst_n(rst_n),
        .push(issue), .push_tag(issue_tag), .full(aq_full),
        .pop(rs_valid), .head_tag(head_tag), .empty(aq_empty)
    );

    sipf_align u_align (
        .clk(clk), .rst_n(rst_n),
        .rs_valid(rs_valid), .rs_data(rs_data), .rs_tag(head_tag),
        .wr_n(wr_n), .wr_d0(wr_d0), .wr_d1(wr_d1)
    );

    sipf_stream_buf #(.DEPTH(SBUF_DEPTH)) u_sbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_n(wr_n), .wr_d0(wr_d0), .wr_d1(wr_d1),
        .rd_en(el_pop), .rd_data(el_data), .not_empty(el_valid)
    );

    // R5
    rs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> !aq_empty);

    // R7
    el_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid && !el_ready |=> el_valid && $stable(el_data));
endmodule

// File: tb/stream_prefetch_in_tb.sv
module stream_prefetch_in_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int SBUF_DEPTH = 8;
    localparam int AQ_DEPTH   = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ea_valid, ea_ready;
    logic [31:0] ea_addr;
    logic        rq_valid, rq_ready;
    logic [31:0] rq_addr;
    logic        rs_valid;
    logic [31:0] rs_data;
    logic        el_valid, el_ready;
    logic [15:0] el_data;

    always #(HALF) clk = ~clk;

    stream_prefetch_in #(.ADDR_W(32), .SBUF_DEPTH(SBUF_DEPTH), .AQ_DEPTH(AQ_DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ea_valid(ea_valid), .ea_ready(ea_ready), .ea_addr(ea_addr),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
        .rs_valid(rs_valid), .rs_data(rs_data),
        .el_valid(el_valid), .el_ready(el_ready), .el_data(el_data)
    );

    int nchk = 0;
    int nfail = 0;

    // model state
    int feed[$];
    int feed_idx;
    bit gap_mode, gap_hold;
    int exp_req[$];
    int exp_req_n[$];
    int exp_el[$];
    int bus_line[$];
    int bus_due[$];
    int cyc, case_cyc, lat, rq_mode, el_mode, stall_len;
    int inflight, req_elems, popped;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(int line);
        logic [15:0] b;
        b = line[15:0];
        return {b ^ 16'h5A3C, b + 16'h0101};
    endfunction

    function automatic int elem_of(int a);
        logic [31:0] w;
        w = word_of(a & ~3);
        return a[1] ? int'(w[31:16]) : int'(w[15:0]);
    endfunction

    task automatic step();
        @(negedge clk);
        cyc++;
        case_cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (feed_idx < feed.size() && !(gap_mode && gap_hold)) begin
            ea_valid = 1'b1;
            ea_addr  = feed[feed_idx];
        end else begin
            ea_valid = 1'b0;
            ea_addr  = 32'h0;
        end
        rq_ready = (rq_mode == 0) ? 1'b1 : lfsr[0];
        if (el_mode == 0)      el_ready = 1'b1;
        else if (el_mode == 1) el_ready = lfsr[3];
        else                   el_ready = (case_cyc > stall_len);
        if (bus_line.size() > 0 && bus_due[0] <= cyc) begin
            rs_valid = 1'b1;
            rs_data  = word_of(bus_line[0]);
        end else begin
            rs_valid = 1'b0;
            rs_data  = 32'h0;
        end
        #(HALF - 1);
        if (ea_valid && ea_ready) begin
            feed_idx++;
            gap_hold = 1'b1;
        end else gap_hold = 1'b0;
        if (rs_valid) begin
            void'(bus_line.pop_front());
            void'(bus_due.pop_front());
            inflight--;
        end
        if (rq_valid && rq_ready) begin
            if (exp_req.size() == 0) begin
                chk(0, "R3", "unexpected request", int'(rq_addr), -1);
            end else begin
                int e, n;
                e = exp_req.pop_front();
                n = exp_req_n.pop_front();
                // R2 line address, R3 merge pattern
                chk(int'(rq_addr) == e, "R2", "request line address", int'(rq_addr), e);
                bus_line.push_back(e);
                bus_due.push_back(cyc + lat);
                inflight++;
                req_elems += n;
            end
        end
        if (el_valid && el_ready) begin
            if (exp_el.size() == 0) begin
                chk(0, "R7", "element with none expected", int'(el_data), -1);
            end else begin
                int e;
                e = exp_el.pop_front();
                // R5 half selection, R6 order
                chk(int'(el_data) == e, "R6", "element data/order", int'(el_data), e);
                popped++;
            end
        end
        // R4 both prefetch limits
        chk(inflight <= AQ_DEPTH, "R4", "outstanding requests", inflight, AQ_DEPTH);
        chk(req_elems - popped <= SBUF_DEPTH, "R4", "promised elements", req_elems - popped, SBUF_DEPTH);
    endtask

    task automatic run_case(input int addrs[$], input bit gapped, input int lt,
                            input int rqm, input int elm, input int stl);
        int i, guard;
        feed = addrs;
        feed_idx = 0;
        gap_mode = gapped;
        gap_hold = 1'b0;
        lat = lt; rq_mode = rqm; el_mode = elm; stall_len = stl;
        case_cyc = 0;
        req_elems = 0; popped = 0;
        exp_req.delete(); exp_req_n.delete(); exp_el.delete();
        foreach (addrs[k]) exp_el.push_back(elem_of(addrs[k]));
        i = 0;
        while (i < addrs.size()) begin
            if (!gapped && i + 1 < addrs.size() && (addrs[i] >>> 2) == (addrs[i+1] >>> 2)) begin
                exp_req.push_back(addrs[i] & ~3); exp_req_n.push_back(2); i += 2;
            end else begin
                exp_req.push_back(addrs[i] & ~3); exp_req_n.push_back(1); i += 1;
            end
        end
        guard = 0;
        while ((popped < addrs.size() || bus_line.size() > 0) && guard < 3000) begin
            step();
            guard++;
        end
        chk(guard < 3000, "R6", "case completion", popped, addrs.size());
        chk(exp_req.size() == 0, "R3", "requests left unissued", exp_req.size(), 0);
        el_mode = 0;
        for (int j = 0; j < 4; j++) step();
        // R7 nothing left once stream drained
        chk(el_valid == 1'b0, "R7", "el_valid after drain", el_valid, 0);
        chk(rq_valid == 1'b0, "R3", "rq_valid after drain", rq_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog expired R6 actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int q[$];
        int steps[8] = '{2, 2, 6, -2, 0, 4, 2, 10};
        int a;
        rst_n = 1'b0;
        ea_valid = 1'b0; ea_addr = 32'h0;
        rq_ready = 1'b0; rs_valid = 1'b0; rs_data = 32'h0; el_ready = 1'b0;
        cyc = 0; inflight = 0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(rq_valid == 1'b0, "R1", "rq_valid in reset", rq_valid, 0);
        chk(el_valid == 1'b0, "R1", "el_valid in reset", el_valid, 0);
        chk(ea_ready == 1'b1, "R1", "ea_ready in reset", ea_ready, 1);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(rq_valid == 1'b0 && el_valid == 1'b0 && ea_ready == 1'b1, "R1",
            "outputs after release", {rq_valid, el_valid, ea_ready}, 3'b001);

        // ascending pairs (R3 R5 R6)
        q.delete(); for (int k = 0; k < 16; k++) q.push_back(32'h100 + 2 * k);
        run_case(q, 0, 3, 0, 0, 0);
        // bit 0 ignored (R2)
        q = '{32'h201, 32'h203, 32'h205, 32'h207, 32'h209};
        run_case(q, 0, 2, 0, 0, 0);
        // descending inside each line (R6)
        q.delete(); for (int k = 0; k < 8; k++) q.push_back(32'h30E - 2 * k);
        run_case(q, 0, 4, 0, 0, 0);
        // one element per line, upper halves (R3 R5)
        q.delete(); for (int k = 0; k < 8; k++) q.push_back(32'h402 + 4 * k);
        run_case(q, 0, 3, 0, 0, 0);
        // gaps in address supply split pairs (R3)
        q.delete(); for (int k = 0; k < 8; k++) q.push_back(32'h600 + 2 * k);
        run_case(q, 1, 3, 0, 0, 0);
        // repeated address merges and duplicates (R3 R6)
        q = '{32'h500, 32'h500, 32'h502, 32'h502, 32'h500};
        run_case(q, 0, 2, 0, 0, 0);
        // consumer stall fills every credit (R4 R7)
        q.delete(); for (int k = 0; k < 24; k++) q.push_back(32'h700 + 2 * k);
        run_case(q, 0, 5, 0, 2, 60);
        // long latency, mixed strides, random handshakes (R4)
        q.delete(); a = 32'h800;
        for (int k = 0; k < 40; k++) begin q.push_back(a); a += steps[k % 8]; end
        run_case(q, 0, 12, 1, 1, 0);
        // single-element lines with long latency fill the address queue (R4)
        q.delete(); for (int k = 0; k < 16; k++) q.push_back(32'hA00 + 8 * k);
        run_case(q, 0, 15, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule